// File: doc/BRIEF.md
# Ordered Store Queue with Blocking Drain

This block decouples a processor's store path from a memory write port. A store presented with its address, data and byte-lane mask is taken in one cycle while the queue has room, so the core keeps issuing work without waiting on memory. Buffered entries leave through a valid/ready write port, one per handshake, oldest first. The memory side may therefore hold back writes and take them whenever its bus cycles are cheapest.

Six ordering events share one vector input: an exception or interrupt, a serializing instruction, an I/O access, a locked operation, a store fence and a full fence. Any of them makes the queue empty itself completely before the triggering operation may go ahead. From the cycle after the event, a busy output stays high and new stores are refused until the last buffered write has been handed to memory. In the first cycle that the queue is seen empty, a one-cycle done pulse is raised and busy then falls.

Top module: `store_drain_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `st_ready` is 1 and `mem_valid`, `drain_busy` and `drain_done` are 0.
- R2: While the queue holds fewer than DEPTH (8) entries and no drain is pending, `st_ready` is 1, and a store with `st_valid` high is taken at that clock edge.
- R3: `mem_addr`, `mem_data` and `mem_be` always show the oldest entry still held. Entries leave in exactly the order they were taken.
- R4: An entry leaves only at an edge where `mem_valid` and `mem_ready` are both 1. While `mem_ready` is 0, the presented entry stays unchanged.
- R5: With DEPTH entries held, `st_ready` is 0, even in a cycle where an entry leaves.
- R6: A store taken in the same cycle that an entry leaves leaves the occupancy unchanged.
- R7: Bit k of `drain_evt` (0 exception/interrupt, 1 serialize, 2 I/O, 3 lock, 4 store fence, 5 full fence), if high at an edge, sets `drain_busy` from the next cycle, and `st_ready` is 0 while `drain_busy` is 1.
- R8: `drain_done` is 1 exactly in cycles where `drain_busy` is 1 and the queue is empty. `drain_busy` falls after that cycle unless a new event arrives at the same edge.
- R9: An event raised while the queue is already empty gives `drain_done` in the very next cycle.
- R10: A store taken at the same edge as an event is counted before the event: it is buffered and written to memory before `drain_done`.
- R11: `mem_valid` is 1 exactly when the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte-lane mask |
| drain_evt | input | 6 | Ordering events, one bit per kind |
| drain_busy | output | 1 | Drain pending, requester held back |
| drain_done | output | 1 | One-cycle pulse when the pending drain completes |
| mem_valid | output | 1 | An entry is presented to memory |
| mem_ready | input | 1 | Memory takes the presented entry |
| mem_addr | output | 32 | Address of the oldest entry |
| mem_data | output | 32 | Data of the oldest entry |
| mem_be | output | 4 | Byte-lane mask of the oldest entry |

## Verification
Every output here is a function of registered state alone. A store or pop at an edge shows on `mem_*`, `mem_valid` and `st_ready` in the cycle after that edge. An event shows on `drain_busy` one cycle later, and `drain_done` comes in the first cycle after that in which the queue is empty. That cycle is the very next one if the queue was already empty. The bench drives inputs at the falling edge and compares outputs a moment later against a queue model advanced once per rising edge, so each result is checked in the cycle it is due. Directed checks for empty-queue events, coincident store-and-event and push-with-pop at the boundary read the outputs just after the edge that should change them.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  // Ordering events that force a full drain; bit positions of drain_evt.
  typedef enum int unsigned {
    EV_EXCEPT    = 0,
    EV_SERIALIZE = 1,
    EV_IO        = 2,
    EV_LOCK      = 3,
    EV_SFENCE    = 4,
    EV_MFENCE    = 5
  } drain_ev_e;

  localparam int unsigned NUM_EVT = 6;
endpackage

// File: rtl/sdb_fifo.sv
module sdb_fifo #(
  parameter int unsigned W     = 68,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // Storage: datapath registers, written only when enabled, no reset.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_ptr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[i] <= wdata;
      end
    end
  end

  // Next-state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign rdata = slot_q[rd_ptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/sdb_drain_ctl.sv
module sdb_drain_ctl #(
  parameter int unsigned NEVT = sdb_pkg::NUM_EVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt,
  input  logic            empty,
  output logic            busy,
  output logic            done
);
  logic busy_q, busy_d;
  logic evt_any;

  assign evt_any = |evt;
  assign done    = busy_q && empty;

  // A new event wins over completion so that it gets a drain of its own.
  always_comb begin
    busy_d = busy_q;
    if (evt_any) begin
      busy_d = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NEVT  = sdb_pkg::NUM_EVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic [NEVT-1:0] drain_evt,
  output logic            drain_busy,
  output logic            drain_done,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_data,
  output logic [DW/8-1:0] mem_be
);
  localparam int unsigned BW = DW / 8;
  localparam int unsigned EW = AW + DW + BW;

  logic          q_empty, q_full;
  logic          push, pop;
  logic [EW-1:0] wr_ent, rd_ent;

  assign st_ready = !q_full && !drain_busy;
  assign push     = st_valid && st_ready;
  assign mem_valid = !q_empty;
  assign pop      = mem_valid && mem_ready;

  assign wr_ent = {st_addr, st_data, st_be};
  assign {mem_addr, mem_data, mem_be} = rd_ent;

  sdb_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (wr_ent),
    .rdata (rd_ent),
    .empty (q_empty),
    .full  (q_full)
  );

  sdb_drain_ctl #(.NEVT(NEVT)) u_drain (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (drain_evt),
    .empty (q_empty),
    .busy  (drain_busy),
    .done  (drain_done)
  );
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned NEVT = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            st_ready,
  input logic [NEVT-1:0] drain_evt,
  input logic            drain_busy,
  input logic            drain_done,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_data,
  input logic [DW/8-1:0] mem_be
);
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)); // R4

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> !st_ready); // R7

  AST_EVENT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|drain_evt) |=> drain_busy); // R7

  AST_DONE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> drain_busy && !mem_valid); // R8

  AST_DONE_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy && !mem_valid |-> drain_done); // R8

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done && !(|drain_evt) |=> !drain_busy); // R8

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy && !drain_done |=> drain_busy); // R8
endmodule

bind store_drain_buffer sdb_checker #(.AW(AW), .DW(DW), .NEVT(NEVT)) u_sdb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_ready   (st_ready),
  .drain_evt  (drain_evt),
  .drain_busy (drain_busy),
  .drain_done (drain_done),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .mem_be     (mem_be)
);

// File: tb/tb_store_drain_buffer.sv
`timescale 1ns/1ps
module tb_store_drain_buffer;
  localparam int DEPTH = 8;

  logic        clk;
  logic        rst_n;
  logic        st_valid;
  logic        st_ready;
  logic [31:0] st_addr, st_data;
  logic [3:0]  st_be;
  logic [5:0]  drain_evt;
  logic        drain_busy, drain_done;
  logic        mem_valid, mem_ready;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_be;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  b;
  } ent_t;

  ent_t q[$];
  bit   pend;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  int   seq = 0;

  store_drain_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .drain_evt(drain_evt), .drain_busy(drain_busy), .drain_done(drain_done),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Compare outputs with the model, then advance the model by one edge.
  task automatic step(input bit sv, input bit [5:0] ev, input bit mr);
    bit exp_rdy, exp_mv, exp_done, acc, popd;
    string rtag;
    @(negedge clk);
    seq++;
    st_valid  = sv;
    st_addr   = 32'h1000_0000 + seq * 4;
    st_data   = seq * 32'h9E37_79B9;
    st_be     = 4'(seq) | 4'b0001;
    drain_evt = ev;
    mem_ready = mr;
    #1;
    exp_rdy  = !pend && (q.size() < DEPTH);
    exp_mv   = (q.size() != 0);
    exp_done = pend && (q.size() == 0);
    rtag = pend ? "R7" : ((q.size() == DEPTH) ? "R5" : "R2");
    chk(st_ready === exp_rdy, rtag, "st_ready", 68'(st_ready), 68'(exp_rdy));
    chk(mem_valid === exp_mv, "R11", "mem_valid", 68'(mem_valid), 68'(exp_mv));
    chk(drain_busy === pend, "R7", "drain_busy", 68'(drain_busy), 68'(pend));
    chk(drain_done === exp_done, "R8", "drain_done", 68'(drain_done), 68'(exp_done));
    if (exp_mv)
      chk({mem_addr, mem_data, mem_be} === {q[0].a, q[0].d, q[0].b}, "R3", "head entry",
          {mem_addr, mem_data, mem_be}, {q[0].a, q[0].d, q[0].b});
    acc  = sv && exp_rdy;
    popd = exp_mv && mr;
    if (popd) void'(q.pop_front());
    if (acc) q.push_back('{a: st_addr, d: st_data, b: st_be});
    if (ev != 0) pend = 1;
    else if (exp_done) pend = 0;
    @(posedge clk);
  endtask

  task automatic empty_out();
    while (q.size() != 0 || pend) step(0, 0, 1);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 20000; wd++) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 68'(wd), 68'(0));
    summary();
  end

  initial begin
    rst_n = 0; st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    drain_evt = 0; mem_ready = 0; pend = 0;
    repeat (3) @(negedge clk);
    chk(st_ready === 1'b1 && mem_valid === 1'b0 && drain_busy === 1'b0 && drain_done === 1'b0,
        "R1", "outputs in reset", 68'({st_ready, mem_valid, drain_busy, drain_done}), 68'(4'b1000));
    rst_n = 1;
    @(posedge clk); #2;
    chk(st_ready === 1'b1 && mem_valid === 1'b0 && drain_busy === 1'b0 && drain_done === 1'b0,
        "R1", "outputs after release", 68'({st_ready, mem_valid, drain_busy, drain_done}), 68'(4'b1000));

    // R5: fill with memory stalled, then try a store while popping at full.
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0);
    #2;
    chk(st_ready === 1'b0, "R5", "st_ready at full", 68'(st_ready), 68'(0));
    step(1, 0, 1);
    #2;
    chk(mem_valid === 1'b1, "R5", "seven left after pop at full", 68'(mem_valid), 68'(1));
    empty_out();

    // R6: seven held, push with pop keeps room for one more.
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0);
    step(1, 0, 1);
    #2;
    chk(st_ready === 1'b1, "R6", "room after push+pop", 68'(st_ready), 68'(1));
    step(1, 0, 0);
    #2;
    chk(st_ready === 1'b0, "R6", "full after one more push", 68'(st_ready), 68'(0));
    empty_out();

    // R3 R4: random traffic with sporadic events.
    for (int i = 0; i < 600; i++) begin
      bit [5:0] ev;
      ev = (($urandom % 25) == 0) ? 6'(1 << ($urandom % 6)) : 6'd0;
      step(($urandom % 3) != 0, ev, ($urandom % 2) == 1);
    end
    empty_out();

    // R9 R7: each event kind on an empty queue.
    for (int k = 0; k < 6; k++) begin
      step(0, 6'(1 << k), 1);
      #2;
      chk(drain_busy === 1'b1 && drain_done === 1'b1, "R9", "done one cycle after event",
          68'({drain_busy, drain_done}), 68'(2'b11));
      step(0, 0, 1);
      #2;
      chk(drain_busy === 1'b0, "R8", "busy cleared after done", 68'(drain_busy), 68'(0));
    end

    // R10: store taken together with a store-fence event.
    step(1, 6'b010000, 0);
    #2;
    chk(mem_valid === 1'b1 && drain_busy === 1'b1 && drain_done === 1'b0, "R10",
        "coincident store buffered", 68'({mem_valid, drain_busy, drain_done}), 68'(3'b110));
    step(1, 0, 1);
    #2;
    chk(drain_done === 1'b1 && mem_valid === 1'b0, "R10", "done after store written",
        68'({drain_done, mem_valid}), 68'(2'b10));
    empty_out();
    step(0, 0, 0);
    summary();
  end
endmodule